// File: doc/BRIEF.md
# MII to RMII Bridge

This block joins a MAC that speaks the four-bit media independent interface to a line-side port that speaks the two-bit reduced interface. The whole block runs on the single reference clock of the reduced side. Nothing on the MAC side is clocked separately. Instead the bridge produces a nibble tick, a one-cycle strobe that stands in for the MAC transmit clock. It also produces a receive strobe that marks each rebuilt nibble.

On transmit, the nibble and its valid and error flags are captured on a nibble tick. The nibble then leaves as two two-bit pairs, low pair first. On receive, the merged carrier/valid input and the two-bit data are sampled once per pair slot. Pairs that arrive before the first `01` pair are dropped. From that `01` pair onward, pairs are joined into nibbles. The rate input picks between one pair per clock (100 Mb/s) and one pair every `SLOW_HOLD` clocks (10 Mb/s, default 10).

Top module: `mii_rmii_bridge`

## Requirements
- R1: While reset is high, and in the first cycle after it, `red_tx_valid`, `red_tx_pair`, `mac_rx_valid`, `mac_rx_nib`, `mac_rx_err` and `mac_rx_stb` are all zero.
- R2: A nibble captured on a `nib_tick` cycle appears on `red_tx_pair` as bits [1:0] from the next cycle, then as bits [3:2] one pair slot later. `red_tx_valid` follows the captured valid flag for both pairs.
- R3: When the captured valid flag is low, `red_tx_pair` is `00` and `red_tx_valid` is 0, whatever the nibble and error inputs are.
- R4: With `rate_fast`=1, the transmit pair advances every clock and `nib_tick` repeats every 2 clocks. With `rate_fast`=0, each pair is held for `SLOW_HOLD` clocks and `nib_tick` repeats every 2×`SLOW_HOLD` clocks.
- R5: A nibble captured with both valid and error high is sent as the pair `11` in both of its slots.
- R6: While `red_rx_live` is high, received pairs before the first `01` pair are discarded. That `01` pair becomes the low half of the first nibble. Each later pair alternates between low half and high half, and `mac_rx_nib` = {high pair, low pair}.
- R7: `mac_rx_stb` is high for exactly one cycle per rebuilt nibble. That cycle is the one after the high pair is sampled. In that cycle `mac_rx_valid` is 1.
- R8: A pair slot sampled with `red_rx_live` low clears `mac_rx_valid`, `mac_rx_nib` and `mac_rx_err` on the next cycle. It also discards any half-built nibble, so the next frame must again start with a `01` pair.
- R9: `mac_rx_err` is presented with a nibble, and is 1 if `red_rx_err` was high at either of that nibble's two samples.
- R10: With `rate_fast`=0, the receive side samples only once per `SLOW_HOLD` clocks, so each pair must be held for that long.
- R11: When the transmit outputs are looped back to the receive inputs, a stream that starts with preamble nibbles comes back as the same nibble sequence, and `mac_rx_valid` falls after the stream ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of the reduced interface |
| rst | input | 1 | Synchronous active-high reset |
| rate_fast | input | 1 | 1 selects 100 Mb/s pacing, 0 selects 10 Mb/s |
| nib_tick | output | 1 | Transmit nibble is captured at the clock edge that ends this cycle |
| mac_tx_valid | input | 1 | Transmit nibble valid from the MAC |
| mac_tx_err | input | 1 | Transmit error from the MAC |
| mac_tx_nib | input | 4 | Transmit nibble from the MAC |
| red_tx_valid | output | 1 | Transmit valid toward the line side |
| red_tx_pair | output | 2 | Transmit two-bit pair toward the line side |
| red_rx_live | input | 1 | Merged carrier/valid from the line side |
| red_rx_pair | input | 2 | Received two-bit pair |
| red_rx_err | input | 1 | Receive error from the line side |
| mac_rx_valid | output | 1 | Receive nibble valid toward the MAC |
| mac_rx_nib | output | 4 | Rebuilt receive nibble |
| mac_rx_err | output | 1 | Receive error for the presented nibble |
| mac_rx_stb | output | 1 | One-cycle strobe marking a new receive nibble |

## Verification
Some properties are checked by the assertions on every clock:
- the transmit pair is zero whenever transmit valid is low;
- the transmit outputs stay still between pair slots;
- an errored nibble is sent as `11`;
- the receive strobe is single, always carries valid, and only ever comes with it;
- a dead carrier clears the receive outputs.

Other behaviours depend on values carried over several slots, so only the bench scenarios can show them: low-pair-first ordering, the discard of pairs before `01`, the exact spacing of the nibble ticks, error merging across two samples, and faithful loopback of a whole stream.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int PAIR_W = 2;
    localparam int NIB_W  = 2 * PAIR_W;

    typedef logic [PAIR_W-1:0] pair_t;
    typedef logic [NIB_W-1:0]  nib_t;

    localparam pair_t IDLE_PAIR  = 2'b00;
    localparam pair_t ERR_PAIR   = 2'b11;
    localparam pair_t START_PAIR = 2'b01;

    typedef struct packed {
        logic valid;
        logic err;
        nib_t nib;
    } tx_word_t;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_LOW,
        RX_HIGH
    } rx_state_e;

    // Choose the pair to send for one half of a captured transmit word.
    function automatic pair_t pick_pair(tx_word_t w, logic upper);
        if (!w.valid)
            return IDLE_PAIR;
        if (w.err)
            return ERR_PAIR;
        return upper ? w.nib[NIB_W-1:PAIR_W] : w.nib[PAIR_W-1:0];
    endfunction

endpackage

// File: rtl/bridge_pacer.sv
module bridge_pacer #(
    parameter int HOLD = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_fast,
    output logic pair_stb,
    output logic upper,
    output logic nib_tick
);

    localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

    logic [CNT_W-1:0] div_q;
    logic             upper_q;

    assign pair_stb = rate_fast || (div_q == '0);
    assign upper    = upper_q;
    assign nib_tick = pair_stb && !upper_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            upper_q <= 1'b0;
        end else begin
            if (rate_fast || div_q == LAST)
                div_q <= '0;
            else
                div_q <= div_q + 1'b1;
            if (pair_stb)
                upper_q <= ~upper_q;
        end
    end

    generate
        if (HOLD > 1) begin : g_gap_chk
            // At the slow rate a pair slot is never followed directly by another.
            assert_slow_gap_R4: assert property (@(posedge clk) disable iff (rst)
                (!rate_fast && pair_stb) |=> (rate_fast || !pair_stb));
        end
    endgenerate

endmodule

// File: rtl/bridge_tx.sv
module bridge_tx
    import bridge_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pair_stb,
    input  logic  upper,
    input  logic  mac_tx_valid,
    input  logic  mac_tx_err,
    input  nib_t  mac_tx_nib,
    output logic  red_tx_valid,
    output pair_t red_tx_pair
);

    tx_word_t word_q;
    tx_word_t word_in;

    assign word_in = '{valid: mac_tx_valid, err: mac_tx_err, nib: mac_tx_nib};

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q       <= '0;
            red_tx_valid <= 1'b0;
            red_tx_pair  <= IDLE_PAIR;
        end else if (pair_stb) begin
            if (!upper) begin
                word_q       <= word_in;
                red_tx_valid <= word_in.valid;
                red_tx_pair  <= pick_pair(word_in, 1'b0);
            end else begin
                red_tx_pair  <= pick_pair(word_q, 1'b1);
            end
        end
    end

    // An idle transmit output never carries a non-zero pair.
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !red_tx_valid |-> red_tx_pair == IDLE_PAIR);

    // Outside a pair slot the transmit outputs hold their value.
    assert_hold_pair_R4: assert property (@(posedge clk) disable iff (rst)
        !pair_stb |=> ($stable(red_tx_pair) && $stable(red_tx_valid)));

    // A captured errored nibble goes out as the error pair.
    assert_err_pattern_R5: assert property (@(posedge clk) disable iff (rst)
        (pair_stb && !upper && mac_tx_valid && mac_tx_err) |=> red_tx_pair == ERR_PAIR);

endmodule

// File: rtl/bridge_rx.sv
module bridge_rx
    import bridge_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pair_stb,
    input  logic  red_rx_live,
    input  pair_t red_rx_pair,
    input  logic  red_rx_err,
    output logic  mac_rx_valid,
    output nib_t  mac_rx_nib,
    output logic  mac_rx_err,
    output logic  mac_rx_stb
);

    rx_state_e state_q;
    pair_t     low_q;
    logic      err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= RX_HUNT;
            low_q        <= IDLE_PAIR;
            err_q        <= 1'b0;
            mac_rx_valid <= 1'b0;
            mac_rx_nib   <= '0;
            mac_rx_err   <= 1'b0;
            mac_rx_stb   <= 1'b0;
        end else begin
            mac_rx_stb <= 1'b0;
            if (pair_stb) begin
                if (!red_rx_live) begin
                    state_q      <= RX_HUNT;
                    mac_rx_valid <= 1'b0;
                    mac_rx_nib   <= '0;
                    mac_rx_err   <= 1'b0;
                end else begin
                    case (state_q)
                        RX_HUNT: begin
                            if (red_rx_pair == START_PAIR) begin
                                low_q   <= red_rx_pair;
                                err_q   <= red_rx_err;
                                state_q <= RX_HIGH;
                            end
                        end
                        RX_LOW: begin
                            low_q   <= red_rx_pair;
                            err_q   <= red_rx_err;
                            state_q <= RX_HIGH;
                        end
                        RX_HIGH: begin
                            mac_rx_nib   <= {red_rx_pair, low_q};
                            mac_rx_err   <= err_q | red_rx_err;
                            mac_rx_valid <= 1'b1;
                            mac_rx_stb   <= 1'b1;
                            state_q      <= RX_LOW;
                        end
                        default: state_q <= RX_HUNT;
                    endcase
                end
            end
        end
    end

    // A nibble strobe always comes with valid data.
    assert_stb_valid_R7: assert property (@(posedge clk) disable iff (rst)
        mac_rx_stb |-> mac_rx_valid);

    // The strobe lasts a single cycle.
    assert_stb_single_R7: assert property (@(posedge clk) disable iff (rst)
        mac_rx_stb |=> !mac_rx_stb);

    // A dead carrier at a sample clears the receive outputs.
    assert_carrier_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (pair_stb && !red_rx_live) |=> (!mac_rx_valid && mac_rx_nib == '0 && !mac_rx_err));

endmodule

// File: rtl/mii_rmii_bridge.sv
module mii_rmii_bridge
    import bridge_pkg::*;
#(
    parameter int SLOW_HOLD = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rate_fast,
    output logic       nib_tick,
    input  logic       mac_tx_valid,
    input  logic       mac_tx_err,
    input  logic [3:0] mac_tx_nib,
    output logic       red_tx_valid,
    output logic [1:0] red_tx_pair,
    input  logic       red_rx_live,
    input  logic [1:0] red_rx_pair,
    input  logic       red_rx_err,
    output logic       mac_rx_valid,
    output logic [3:0] mac_rx_nib,
    output logic       mac_rx_err,
    output logic       mac_rx_stb
);

    logic pair_stb;
    logic upper;

    bridge_pacer #(.HOLD(SLOW_HOLD)) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .rate_fast (rate_fast),
        .pair_stb  (pair_stb),
        .upper     (upper),
        .nib_tick  (nib_tick)
    );

    bridge_tx u_tx (
        .clk          (clk),
        .rst          (rst),
        .pair_stb     (pair_stb),
        .upper        (upper),
        .mac_tx_valid (mac_tx_valid),
        .mac_tx_err   (mac_tx_err),
        .mac_tx_nib   (mac_tx_nib),
        .red_tx_valid (red_tx_valid),
        .red_tx_pair  (red_tx_pair)
    );

    bridge_rx u_rx (
        .clk          (clk),
        .rst          (rst),
        .pair_stb     (pair_stb),
        .red_rx_live  (red_rx_live),
        .red_rx_pair  (red_rx_pair),
        .red_rx_err   (red_rx_err),
        .mac_rx_valid (mac_rx_valid),
        .mac_rx_nib   (mac_rx_nib),
        .mac_rx_err   (mac_rx_err),
        .mac_rx_stb   (mac_rx_stb)
    );

endmodule

// File: tb/mii_rmii_bridge_test.sv
`timescale 1ns/1ps
module mii_rmii_bridge_test;

    localparam int HOLD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rate_fast = 1'b1;
    logic       nib_tick;
    logic       tx_valid = 1'b0, tx_err = 1'b0;
    logic [3:0] tx_nib = '0;
    logic       red_tx_valid;
    logic [1:0] red_tx_pair;
    logic       b_live = 1'b0, b_err = 1'b0;
    logic [1:0] b_pair = '0;
    logic       lb = 1'b0;
    logic       rx_live, rx_err_in;
    logic [1:0] rx_pair_in;
    logic       rx_valid, rx_err, rx_stb;
    logic [3:0] rx_nib;

    int checks = 0;
    int fails  = 0;
    int pend   = 0;
    int ncap   = 0;
    logic [3:0] cap [8];

    always #4 clk = ~clk;

    assign rx_live    = lb ? red_tx_valid : b_live;
    assign rx_pair_in = lb ? red_tx_pair  : b_pair;
    assign rx_err_in  = lb ? 1'b0         : b_err;

    mii_rmii_bridge #(.SLOW_HOLD(HOLD)) uut (
        .clk          (clk),
        .rst          (rst),
        .rate_fast    (rate_fast),
        .nib_tick     (nib_tick),
        .mac_tx_valid (tx_valid),
        .mac_tx_err   (tx_err),
        .mac_tx_nib   (tx_nib),
        .red_tx_valid (red_tx_valid),
        .red_tx_pair  (red_tx_pair),
        .red_rx_live  (rx_live),
        .red_rx_pair  (rx_pair_in),
        .red_rx_err   (rx_err_in),
        .mac_rx_valid (rx_valid),
        .mac_rx_nib   (rx_nib),
        .mac_rx_err   (rx_err),
        .mac_rx_stb   (rx_stb)
    );

    // Loopback capture of received nibbles.
    always @(negedge clk) begin
        if (lb && rx_stb && ncap < 8) begin
            cap[ncap] = rx_nib;
            ncap++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Transmit one nibble and check both pairs and the hold time.
    task automatic send_nib(input logic en, input logic er, input logic [3:0] d,
                            input logic [1:0] lo, input logic [1:0] hi, input logic xen);
        int p;
        p = rate_fast ? 1 : HOLD;
        while (!nib_tick) @(negedge clk);
        tx_valid = en; tx_err = er; tx_nib = d;
        @(negedge clk);
        chk("R2 low pair", {30'd0, red_tx_pair}, {30'd0, lo});
        chk("R3 tx valid", {31'd0, red_tx_valid}, {31'd0, xen});
        repeat (p - 1) @(negedge clk);
        chk("R4 pair held", {30'd0, red_tx_pair}, {30'd0, lo});
        @(negedge clk);
        chk("R2 high pair", {30'd0, red_tx_pair}, {30'd0, hi});
    endtask

    // Drive one received pair for one slot; outputs are checked after return.
    task automatic put(input logic live, input logic [1:0] pr, input logic er);
        repeat (pend) @(negedge clk);
        b_live = live; b_pair = pr; b_err = er;
        @(negedge clk);
        pend = rate_fast ? 0 : HOLD - 1;
    endtask

    task automatic tick_gap(input int exp, input string tag);
        int n;
        while (!nib_tick) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!nib_tick);
        chk(tag, n, exp);
    endtask

    // Fields: valid, err, nibble, low pair, high pair, expected valid.
    localparam logic [10:0] TXV [7] = '{
        {1'b1, 1'b0, 4'hA, 2'b10, 2'b10, 1'b1},
        {1'b1, 1'b0, 4'h6, 2'b10, 2'b01, 1'b1},
        {1'b1, 1'b0, 4'h1, 2'b01, 2'b00, 1'b1},
        {1'b1, 1'b1, 4'h5, 2'b11, 2'b11, 1'b1},
        {1'b0, 1'b0, 4'hF, 2'b00, 2'b00, 1'b0},
        {1'b0, 1'b1, 4'h9, 2'b00, 2'b00, 1'b0},
        {1'b1, 1'b0, 4'hC, 2'b00, 2'b11, 1'b1}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [3:0] exp_stream [5];
        exp_stream = '{4'h5, 4'h5, 4'hD, 4'hA, 4'h3};

        repeat (3) @(negedge clk);
        chk("R1 tx valid in reset", {31'd0, red_tx_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tx pair", {30'd0, red_tx_pair}, 0);
        chk("R1 rx outputs", {25'd0, rx_valid, rx_nib, rx_err, rx_stb}, 0);

        // R2 R3 R5: fast transmit table
        for (int i = 0; i < 7; i++) begin
            send_nib(TXV[i][10], TXV[i][9], TXV[i][8:5], TXV[i][4:3], TXV[i][2:1], TXV[i][0]);
        end
        tick_gap(2, "R4 fast tick gap");

        // R4: slow transmit
        rate_fast = 1'b0;
        send_nib(1'b1, 1'b0, 4'h6, 2'b10, 2'b01, 1'b1);
        send_nib(1'b1, 1'b1, 4'h0, 2'b11, 2'b11, 1'b1);
        tick_gap(2 * HOLD, "R4 slow tick gap");
        tx_valid = 1'b0;

        // R6 R7 R8 R9: fast receive
        rate_fast = 1'b1;
        pend = 0;
        put(1'b0, 2'b00, 1'b0);
        put(1'b1, 2'b00, 1'b0);
        put(1'b1, 2'b10, 1'b0);
        chk("R6 pre-start pairs dropped", {31'd0, rx_valid}, 0);
        put(1'b1, 2'b01, 1'b0);
        chk("R6 start pair no strobe", {31'd0, rx_stb}, 0);
        put(1'b1, 2'b11, 1'b0);
        chk("R6 first nibble", {26'd0, rx_valid, rx_stb, rx_nib}, {26'd0, 2'b11, 4'hD});
        put(1'b1, 2'b10, 1'b0);
        chk("R7 strobe single", {31'd0, rx_stb}, 0);
        chk("R7 nibble held", {28'd0, rx_nib}, 32'hD);
        put(1'b1, 2'b00, 1'b0);
        chk("R6 second nibble", {27'd0, rx_stb, rx_nib}, {27'd0, 1'b1, 4'h2});
        put(1'b1, 2'b01, 1'b1);
        put(1'b1, 2'b01, 1'b0);
        chk("R9 err on low half", {27'd0, rx_err, rx_nib}, {27'd0, 1'b1, 4'h5});
        put(1'b1, 2'b11, 1'b0);
        put(1'b1, 2'b11, 1'b0);
        chk("R9 clean nibble", {27'd0, rx_err, rx_nib}, {27'd0, 1'b0, 4'hF});
        put(1'b0, 2'b00, 1'b0);
        chk("R8 carrier drop", {26'd0, rx_valid, rx_nib, rx_err}, 0);
        put(1'b1, 2'b01, 1'b0);
        put(1'b0, 2'b10, 1'b0);
        chk("R8 partial dropped", {30'd0, rx_valid, rx_stb}, 0);
        put(1'b1, 2'b11, 1'b0);
        put(1'b1, 2'b01, 1'b0);
        chk("R8 needs new start", {31'd0, rx_stb}, 0);
        put(1'b1, 2'b10, 1'b0);
        chk("R8 new frame nibble", {27'd0, rx_stb, rx_nib}, {27'd0, 1'b1, 4'h9});
        put(1'b0, 2'b00, 1'b0);

        // R10: slow receive
        rate_fast = 1'b0;
        @(negedge clk);
        while (!nib_tick) @(negedge clk);
        pend = 0;
        put(1'b1, 2'b01, 1'b0);
        chk("R10 slow low half", {30'd0, rx_valid, rx_stb}, 0);
        put(1'b1, 2'b11, 1'b1);
        chk("R10 slow nibble", {26'd0, rx_stb, rx_err, rx_nib}, {26'd0, 2'b11, 4'hD});
        @(negedge clk);
        chk("R10 slow strobe single", {31'd0, rx_stb}, 0);
        put(1'b0, 2'b00, 1'b0);
        repeat (pend) @(negedge clk);
        chk("R10 slow drop", {31'd0, rx_valid}, 0);

        // R11: loopback at fast rate
        rate_fast = 1'b1;
        lb = 1'b1;
        for (int i = 0; i < 5; i++) begin
            while (!nib_tick) @(negedge clk);
            tx_valid = 1'b1; tx_err = 1'b0; tx_nib = exp_stream[i];
            @(negedge clk);
        end
        while (!nib_tick) @(negedge clk);
        tx_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk("R11 loopback count", ncap, 5);
        for (int i = 0; i < 5; i++) begin
            chk("R11 loopback nibble", {28'd0, cap[i]}, {28'd0, exp_stream[i]});
        end
        chk("R11 valid after end", {31'd0, rx_valid}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule